// File: doc/BRIEF.md
# Windowed Raster Sync Generator

This block produces the pixel and line timing of one readout frame. It advances once for every clock on which the data-clock enable is high. It steps through a virtual frame made of active lines and blank lines. Each line holds an active span followed by horizontal blanking. An optional remainder of idle clocks follows the last line. While the active part of the frame is being walked, the block emits the array row and column address of every selected pixel. It also emits a pixel-valid strobe and horizontal and vertical sync outputs.

The active region is a window of interest: a start point and a size on each axis. Each axis can be sub-sampled by 1, 2, 4 or 8, and each axis can be mirrored. Each sync output can run as a pulse with a programmable start and width, or as a data-valid flag, and either polarity can be selected. All settings arrive on configuration inputs. The block captures them only when a frame begins, so a frame never mixes two settings. Blanking values below the minimum are raised to the minimum when they are captured.

Top module: `raster_sync_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first clock with `dclkEn` high, `pixValid`, `hsync` and `vsync` are 0 and both addresses are 0.
- R2: With effective blanks `hb` and `vb`, a line lasts `(cfgColWidth >> cfgColSub) + hb` enabled clocks. A frame has `(cfgRowDepth >> cfgRowSub) + vb` lines plus `cfgRemainder` idle clocks. `pixValid` is high for the first `cfgColWidth >> cfgColSub` clocks of each of the first `cfgRowDepth >> cfgRowSub` lines, and low everywhere else.
- R3: The effective horizontal blank is the larger of `cfgHBlank` and 60. The effective vertical blank is the larger of `cfgVBlank` and 4.
- R4: A column sub-sample code c (0, 1, 2 or 3) selects every 2^c-th column. The k-th valid pixel of a line then has `colAddr = (cfgColStart with bit 0 cleared) + k*2^c`. `colAddr` is 0 whenever `pixValid` is low.
- R5: A row sub-sample code r selects every 2^r-th row in the same way. Throughout active line j, `rowAddr = cfgRowStart + j*2^r`. `rowAddr` is 0 on lines that are not active.
- R6: With `cfgMirrorH` set, `colAddr = evenStart + cfgColWidth - 1 - k*2^c`. With `cfgMirrorV` set, `rowAddr = cfgRowStart + cfgRowDepth - 1 - j*2^r`.
- R7: In pulse mode (`cfgHsDataMode` = 0), HSYNC is active on every line of the frame at line clocks `cfgHsStart` to `cfgHsStart + cfgHsWidth - 1` that fall inside the line. It is never active during the remainder clocks, and it is never active when the width is 0.
- R8: In pulse mode (`cfgVsDataMode` = 0), VSYNC is active on the whole of lines `cfgVsStart` to `cfgVsStart + cfgVsWidth - 1` that exist in the frame. It is inactive during the remainder clocks.
- R9: In data-valid mode, HSYNC is active exactly when `pixValid` is high. In data-valid mode, VSYNC is active for the whole of every active line.
- R10: A polarity bit of 0 drives the active level high. A polarity bit of 1 inverts that sync output.
- R11: On a clock with `dclkEn` low, the position does not advance and every output holds its value.
- R12: All configuration inputs are captured only on the enabled clock that starts a frame. Changes made in the middle of a frame have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dclkEn | input | 1 | Data-clock enable; the raster advances one position per enabled clock |
| cfgColStart | input | 11 | Window column start; bit 0 is ignored |
| cfgRowStart | input | 11 | Window row start |
| cfgColWidth | input | 11 | Window width in array columns |
| cfgRowDepth | input | 11 | Window depth in array rows |
| cfgColSub | input | 2 | Column sub-sample code |
| cfgRowSub | input | 2 | Row sub-sample code |
| cfgMirrorH | input | 1 | Reverse the column order |
| cfgMirrorV | input | 1 | Reverse the row order |
| cfgHBlank | input | 16 | Horizontal blank in clocks |
| cfgVBlank | input | 13 | Vertical blank in lines |
| cfgRemainder | input | 12 | Idle clocks after the last line |
| cfgHsStart | input | 10 | HSYNC pulse start clock within a line |
| cfgHsWidth | input | 8 | HSYNC pulse width in clocks |
| cfgHsPol | input | 1 | HSYNC polarity (1 = active low) |
| cfgHsDataMode | input | 1 | HSYNC data-valid mode |
| cfgVsStart | input | 10 | VSYNC pulse start line |
| cfgVsWidth | input | 8 | VSYNC pulse width in lines |
| cfgVsPol | input | 1 | VSYNC polarity (1 = active low) |
| cfgVsDataMode | input | 1 | VSYNC data-valid mode |
| pixValid | output | 1 | Current position is a selected pixel |
| colAddr | output | 12 | Array column address of the current pixel |
| rowAddr | output | 12 | Array row address of the current line |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The bench targets these corner cases:

- **Odd column start.** A design that kept bit 0 would put every column address off by one.
- **Blank values below the minimums.** A design that did not clamp them would shorten every line and frame, and the whole position stream would slip.
- **Mirroring combined with sub-sampling.** A design that stepped in the wrong unit or subtracted from the wrong end would produce wrong addresses from the first pixel on.
- **Sync pulses that run past the end of a line or frame, and a width of 0.** A design that wrapped these or mis-compared them would show sync activity on the wrong clocks.
- **Configuration changed mid-frame.** A design without frame-boundary capture would alter the running frame partway through.
- **A sparse enable pattern.** A design that advanced on disabled clocks would drift out of step with the expected stream.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  parameter int ADDR_W     = 11;
  parameter int HB_W       = 16;
  parameter int VB_W       = 13;
  parameter int REM_W      = 12;
  parameter int SYNC_POS_W = 10;
  parameter int SYNC_WID_W = 8;
  parameter int SUB_W      = 2;

  localparam int OUT_W   = ADDR_W + 1;
  localparam int H_MAX_W = (ADDR_W > HB_W) ? ((ADDR_W > REM_W) ? ADDR_W : REM_W)
                                           : ((HB_W > REM_W) ? HB_W : REM_W);
  localparam int H_CNT_W = H_MAX_W + 1;
  localparam int V_CNT_W = ((ADDR_W > VB_W) ? ADDR_W : VB_W) + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [ADDR_W-1:0] size;
    logic [SUB_W-1:0]  sub;
    logic              mirror;
  } axisCfg_t;

  typedef struct packed {
    axisCfg_t              colAxis;
    axisCfg_t              rowAxis;
    logic [HB_W-1:0]       hblank;
    logic [VB_W-1:0]       vblank;
    logic [REM_W-1:0]      remainder;
    logic [SYNC_POS_W-1:0] hsStart;
    logic [SYNC_WID_W-1:0] hsWidth;
    logic                  hsPol;
    logic                  hsDataMode;
    logic [SYNC_POS_W-1:0] vsStart;
    logic [SYNC_WID_W-1:0] vsWidth;
    logic                  vsPol;
    logic                  vsDataMode;
  } frameCfg_t;

  typedef struct packed {
    logic pixOn;
    logic rowOn;
    logic hsPulse;
    logic vsPulse;
  } strobes_t;

  localparam frameCfg_t CFG_RESET = '{
    colAxis:    '{start: ADDR_W'(14), size: ADDR_W'(1280), sub: '0, mirror: 1'b0},
    rowAxis:    '{start: ADDR_W'(14), size: ADDR_W'(1024), sub: '0, mirror: 1'b0},
    hblank:     HB_W'(142),
    vblank:     VB_W'(101),
    remainder:  '0,
    hsStart:    '0,
    hsWidth:    SYNC_WID_W'(32),
    hsPol:      1'b0,
    hsDataMode: 1'b0,
    vsStart:    '0,
    vsWidth:    SYNC_WID_W'(1),
    vsPol:      1'b0,
    vsDataMode: 1'b0
  };
endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
#(
  parameter int HBLANK_MIN = 60,
  parameter int VBLANK_MIN = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dclkEn,
  input  frameCfg_t           cfgIn,
  output axisCfg_t            colAxisS,
  output axisCfg_t            rowAxisS,
  output logic                hsPolS,
  output logic                hsModeS,
  output logic                vsPolS,
  output logic                vsModeS,
  output strobes_t            strb,
  output logic [H_CNT_W-1:0]  hIdx,
  output logic [V_CNT_W-1:0]  vIdx
);
  frameCfg_t            shadow;
  logic                 running;
  logic [H_CNT_W-1:0]   hCnt;
  logic [V_CNT_W-1:0]   vCnt;

  logic [H_CNT_W-1:0]   actCols;
  logic [V_CNT_W-1:0]   actRows;
  logic [H_CNT_W-1:0]   lineLen;
  logic [V_CNT_W-1:0]   numLines;
  logic                 inLines;
  logic                 lineEnd;
  logic                 frameEnd;
  logic [H_CNT_W-1:0]   hsLo;
  logic [H_CNT_W-1:0]   hsHi;
  logic [V_CNT_W-1:0]   vsLo;
  logic [V_CNT_W-1:0]   vsHi;

  function automatic frameCfg_t clampCfg(input frameCfg_t c);
    frameCfg_t r;
    r = c;
    if (c.hblank < HB_W'(HBLANK_MIN)) r.hblank = HB_W'(HBLANK_MIN);
    if (c.vblank < VB_W'(VBLANK_MIN)) r.vblank = VB_W'(VBLANK_MIN);
    return r;
  endfunction

  always_comb begin
    actCols  = H_CNT_W'(shadow.colAxis.size >> shadow.colAxis.sub);
    actRows  = V_CNT_W'(shadow.rowAxis.size >> shadow.rowAxis.sub);
    lineLen  = actCols + H_CNT_W'(shadow.hblank);
    numLines = actRows + V_CNT_W'(shadow.vblank);
    inLines  = vCnt < numLines;
    lineEnd  = hCnt == lineLen - H_CNT_W'(1);
    if (inLines)
      frameEnd = lineEnd && (vCnt == numLines - V_CNT_W'(1)) && (shadow.remainder == '0);
    else
      frameEnd = hCnt == H_CNT_W'(shadow.remainder) - H_CNT_W'(1);
    hsLo = H_CNT_W'(shadow.hsStart);
    hsHi = H_CNT_W'(shadow.hsStart) + H_CNT_W'(shadow.hsWidth);
    vsLo = V_CNT_W'(shadow.vsStart);
    vsHi = V_CNT_W'(shadow.vsStart) + V_CNT_W'(shadow.vsWidth);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow  <= CFG_RESET;
      running <= 1'b0;
      hCnt    <= '0;
      vCnt    <= '0;
    end else if (dclkEn) begin
      if (!running || frameEnd) begin
        shadow  <= clampCfg(cfgIn);
        running <= 1'b1;
        hCnt    <= '0;
        vCnt    <= '0;
      end else if (inLines && lineEnd) begin
        hCnt <= '0;
        vCnt <= vCnt + V_CNT_W'(1);
      end else begin
        hCnt <= hCnt + H_CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb.pixOn   = running && inLines && (vCnt < actRows) && (hCnt < actCols);
    strb.rowOn   = running && (vCnt < actRows);
    strb.hsPulse = running && inLines && (hCnt >= hsLo) && (hCnt < hsHi);
    strb.vsPulse = running && inLines && (vCnt >= vsLo) && (vCnt < vsHi);
  end

  assign colAxisS = shadow.colAxis;
  assign rowAxisS = shadow.rowAxis;
  assign hsPolS   = shadow.hsPol;
  assign hsModeS  = shadow.hsDataMode;
  assign vsPolS   = shadow.vsPol;
  assign vsModeS  = shadow.vsDataMode;
  assign hIdx     = hCnt;
  assign vIdx     = vCnt;
endmodule

// File: rtl/rsg_axis.sv
module rsg_axis
  import rsg_pkg::*;
#(
  parameter int IDX_W      = 12,
  parameter bit EVEN_START = 1'b0
) (
  input  axisCfg_t          cfg,
  input  logic              valid,
  input  logic [IDX_W-1:0]  idx,
  output logic [OUT_W-1:0]  addr
);
  localparam int W = IDX_W + (1 << SUB_W) + 1;

  logic [ADDR_W-1:0] base;
  logic [W-1:0]      offs;

  if (EVEN_START) begin : g_even
    assign base = cfg.start & ~ADDR_W'(1);
  end else begin : g_plain
    assign base = cfg.start;
  end

  assign offs = W'(idx) << cfg.sub;

  always_comb begin
    if (!valid)
      addr = '0;
    else if (cfg.mirror)
      addr = OUT_W'(W'(base) + W'(cfg.size) - W'(1) - offs);
    else
      addr = OUT_W'(W'(base) + offs);
  end
endmodule

// File: rtl/rsg_dp.sv
module rsg_dp
  import rsg_pkg::*;
(
  input  axisCfg_t            colAxis,
  input  axisCfg_t            rowAxis,
  input  logic                hsPol,
  input  logic                hsMode,
  input  logic                vsPol,
  input  logic                vsMode,
  input  strobes_t            strb,
  input  logic [H_CNT_W-1:0]  hIdx,
  input  logic [V_CNT_W-1:0]  vIdx,
  output logic                pixValid,
  output logic [OUT_W-1:0]    colAddr,
  output logic [OUT_W-1:0]    rowAddr,
  output logic                hsync,
  output logic                vsync
);
  rsg_axis #(.IDX_W(H_CNT_W), .EVEN_START(1'b1)) u_colAxis (
    .cfg   (colAxis),
    .valid (strb.pixOn),
    .idx   (hIdx),
    .addr  (colAddr)
  );

  rsg_axis #(.IDX_W(V_CNT_W), .EVEN_START(1'b0)) u_rowAxis (
    .cfg   (rowAxis),
    .valid (strb.rowOn),
    .idx   (vIdx),
    .addr  (rowAddr)
  );

  assign pixValid = strb.pixOn;
  assign hsync    = (hsMode ? strb.pixOn : strb.hsPulse) ^ hsPol;
  assign vsync    = (vsMode ? strb.rowOn : strb.vsPulse) ^ vsPol;
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen
  import rsg_pkg::*;
#(
  parameter int HBLANK_MIN = 60,
  parameter int VBLANK_MIN = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dclkEn,
  input  logic [ADDR_W-1:0]     cfgColStart,
  input  logic [ADDR_W-1:0]     cfgRowStart,
  input  logic [ADDR_W-1:0]     cfgColWidth,
  input  logic [ADDR_W-1:0]     cfgRowDepth,
  input  logic [SUB_W-1:0]      cfgColSub,
  input  logic [SUB_W-1:0]      cfgRowSub,
  input  logic                  cfgMirrorH,
  input  logic                  cfgMirrorV,
  input  logic [HB_W-1:0]       cfgHBlank,
  input  logic [VB_W-1:0]       cfgVBlank,
  input  logic [REM_W-1:0]      cfgRemainder,
  input  logic [SYNC_POS_W-1:0] cfgHsStart,
  input  logic [SYNC_WID_W-1:0] cfgHsWidth,
  input  logic                  cfgHsPol,
  input  logic                  cfgHsDataMode,
  input  logic [SYNC_POS_W-1:0] cfgVsStart,
  input  logic [SYNC_WID_W-1:0] cfgVsWidth,
  input  logic                  cfgVsPol,
  input  logic                  cfgVsDataMode,
  output logic                  pixValid,
  output logic [OUT_W-1:0]      colAddr,
  output logic [OUT_W-1:0]      rowAddr,
  output logic                  hsync,
  output logic                  vsync
);
  frameCfg_t           cfgIn;
  axisCfg_t            colAxisS;
  axisCfg_t            rowAxisS;
  logic                hsPolS;
  logic                hsModeS;
  logic                vsPolS;
  logic                vsModeS;
  strobes_t            strb;
  logic [H_CNT_W-1:0]  hIdx;
  logic [V_CNT_W-1:0]  vIdx;

  always_comb begin
    cfgIn.colAxis    = '{start: cfgColStart, size: cfgColWidth, sub: cfgColSub, mirror: cfgMirrorH};
    cfgIn.rowAxis    = '{start: cfgRowStart, size: cfgRowDepth, sub: cfgRowSub, mirror: cfgMirrorV};
    cfgIn.hblank     = cfgHBlank;
    cfgIn.vblank     = cfgVBlank;
    cfgIn.remainder  = cfgRemainder;
    cfgIn.hsStart    = cfgHsStart;
    cfgIn.hsWidth    = cfgHsWidth;
    cfgIn.hsPol      = cfgHsPol;
    cfgIn.hsDataMode = cfgHsDataMode;
    cfgIn.vsStart    = cfgVsStart;
    cfgIn.vsWidth    = cfgVsWidth;
    cfgIn.vsPol      = cfgVsPol;
    cfgIn.vsDataMode = cfgVsDataMode;
  end

  rsg_ctrl #(.HBLANK_MIN(HBLANK_MIN), .VBLANK_MIN(VBLANK_MIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dclkEn   (dclkEn),
    .cfgIn    (cfgIn),
    .colAxisS (colAxisS),
    .rowAxisS (rowAxisS),
    .hsPolS   (hsPolS),
    .hsModeS  (hsModeS),
    .vsPolS   (vsPolS),
    .vsModeS  (vsModeS),
    .strb     (strb),
    .hIdx     (hIdx),
    .vIdx     (vIdx)
  );

  rsg_dp u_dp (
    .colAxis  (colAxisS),
    .rowAxis  (rowAxisS),
    .hsPol    (hsPolS),
    .hsMode   (hsModeS),
    .vsPol    (vsPolS),
    .vsMode   (vsModeS),
    .strb     (strb),
    .hIdx     (hIdx),
    .vIdx     (vIdx),
    .pixValid (pixValid),
    .colAddr  (colAddr),
    .rowAddr  (rowAddr),
    .hsync    (hsync),
    .vsync    (vsync)
  );
endmodule

// File: rtl/raster_sync_gen_chk.sv
module raster_sync_gen_chk
  import rsg_pkg::*;
#(
  parameter int HBLANK_MIN = 60
) (
  input logic              clk,
  input logic              rstN,
  input logic              dclkEn,
  input logic              pixValid,
  input logic [OUT_W-1:0]  colAddr,
  input logic [OUT_W-1:0]  rowAddr,
  input logic              hsync,
  input logic              vsync,
  input logic              colMirror,
  input logic [SUB_W-1:0]  colSub,
  input logic              hsPol,
  input logic              hsMode,
  input logic              vsPol,
  input logic              vsMode
);
  logic [15:0] gapCnt;
  logic        lastPv;
  logic        seenPix;

  // R11: a disabled clock leaves every output unchanged
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !dclkEn |=> ($stable(pixValid) && $stable(colAddr) && $stable(rowAddr)
                 && $stable(hsync) && $stable(vsync)));

  // R4: consecutive valid pixels step by the sub-sample factor
  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dclkEn && pixValid && !colMirror) |=>
      (!pixValid || colAddr == $past(colAddr) + (OUT_W'(1) << $past(colSub))));

  // R4: no column address outside valid pixels
  assert_col_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |-> colAddr == '0);

  // R9: data-valid HSYNC follows the pixel strobe
  assert_hs_data_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    hsMode |-> hsync == (pixValid ^ hsPol));

  // R9: data-valid VSYNC is active on every valid pixel
  assert_vs_data_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vsMode && pixValid) |-> vsync == !vsPol);

  // R3: the gap between pixel runs of a line is never below the blank minimum
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      lastPv  <= 1'b0;
      seenPix <= 1'b0;
    end else if (dclkEn) begin
      lastPv <= pixValid;
      if (pixValid) begin
        assert_hblank_gap_R3: assert (!seenPix || lastPv || gapCnt >= 16'(HBLANK_MIN))
          else $error("horizontal gap %0d below minimum", gapCnt);
        gapCnt  <= '0;
        seenPix <= 1'b1;
      end else if (gapCnt != 16'hFFFF) begin
        gapCnt <= gapCnt + 16'd1;
      end
    end
  end
endmodule

bind raster_sync_gen raster_sync_gen_chk #(.HBLANK_MIN(HBLANK_MIN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dclkEn    (dclkEn),
  .pixValid  (pixValid),
  .colAddr   (colAddr),
  .rowAddr   (rowAddr),
  .hsync     (hsync),
  .vsync     (vsync),
  .colMirror (colAxisS.mirror),
  .colSub    (colAxisS.sub),
  .hsPol     (hsPolS),
  .hsMode    (hsModeS),
  .vsPol     (vsPolS),
  .vsMode    (vsModeS)
);

// File: tb/raster_sync_gen_bench.sv
`timescale 1ns/1ps
module raster_sync_gen_bench;
  typedef struct {
    int cs, rs, w, d, csub, rsub, mh, mv, hb, vb, rem;
    int hss, hsw, hp, hd, vss, vsw, vp, vd;
  } bcfg_t;

  typedef struct {
    bit    pv, hs, vs;
    int    row, col;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dclkEn = 1'b0;
  logic [10:0] cfgColStart, cfgRowStart, cfgColWidth, cfgRowDepth;
  logic [1:0]  cfgColSub, cfgRowSub;
  logic        cfgMirrorH, cfgMirrorV;
  logic [15:0] cfgHBlank;
  logic [12:0] cfgVBlank;
  logic [11:0] cfgRemainder;
  logic [9:0]  cfgHsStart, cfgVsStart;
  logic [7:0]  cfgHsWidth, cfgVsWidth;
  logic        cfgHsPol, cfgHsDataMode, cfgVsPol, cfgVsDataMode;
  logic        pixValid, hsync, vsync;
  logic [11:0] colAddr, rowAddr;

  int    checks = 0;
  int    fails = 0;
  int    popCount = 0;
  int    enMode = 0;
  int    cyc = 0;
  bit    enGate = 0;
  bit    monOn = 0;
  bit    haveLast = 0;
  item_t q[$];
  item_t lastItem;

  raster_sync_gen u_raster_sync_gen (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    dclkEn = enGate && (enMode == 0 || (cyc % 3) == 0);
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic checkItem(input item_t e, input string tag);
    checks++;
    if (pixValid !== e.pv || hsync !== e.hs || vsync !== e.vs ||
        rowAddr !== 12'(e.row) || colAddr !== 12'(e.col)) begin
      fails++;
      $display("FAIL %s: got pv=%0d hs=%0d vs=%0d row=%0d col=%0d expected pv=%0d hs=%0d vs=%0d row=%0d col=%0d",
               tag, pixValid, hsync, vsync, rowAddr, colAddr, e.pv, e.hs, e.vs, e.row, e.col);
    end
  endtask

  task automatic applyCfg(input bcfg_t c);
    cfgColStart = 11'(c.cs);  cfgRowStart = 11'(c.rs);
    cfgColWidth = 11'(c.w);   cfgRowDepth = 11'(c.d);
    cfgColSub = 2'(c.csub);   cfgRowSub = 2'(c.rsub);
    cfgMirrorH = c.mh[0];     cfgMirrorV = c.mv[0];
    cfgHBlank = 16'(c.hb);    cfgVBlank = 13'(c.vb);
    cfgRemainder = 12'(c.rem);
    cfgHsStart = 10'(c.hss);  cfgHsWidth = 8'(c.hsw);
    cfgHsPol = c.hp[0];       cfgHsDataMode = c.hd[0];
    cfgVsStart = 10'(c.vss);  cfgVsWidth = 8'(c.vsw);
    cfgVsPol = c.vp[0];       cfgVsDataMode = c.vd[0];
  endtask

  // Driver side of the scoreboard: expected stream for one frame, from the requirements
  task automatic build(input bcfg_t c, input string tag, output int n);
    int hb, vb, ac, ar, ll, nl, cse;
    item_t it;
    hb = (c.hb < 60) ? 60 : c.hb;      // R3
    vb = (c.vb < 4) ? 4 : c.vb;        // R3
    ac = c.w >> c.csub;
    ar = c.d >> c.rsub;
    ll = ac + hb;
    nl = ar + vb;
    cse = c.cs & ~1;
    n = 0;
    for (int v = 0; v < nl; v++) begin
      for (int h = 0; h < ll; h++) begin
        bit hsOn, vsOn;
        it.tag = tag;
        it.pv = (v < ar) && (h < ac);
        if (it.pv) it.col = c.mh ? cse + c.w - 1 - (h << c.csub) : cse + (h << c.csub);
        else       it.col = 0;
        if (v < ar) it.row = c.mv ? c.rs + c.d - 1 - (v << c.rsub) : c.rs + (v << c.rsub);
        else        it.row = 0;
        hsOn = c.hd ? it.pv : (h >= c.hss && h < c.hss + c.hsw);
        vsOn = c.vd ? (v < ar) : (v >= c.vss && v < c.vss + c.vsw);
        it.hs = hsOn ^ c.hp[0];
        it.vs = vsOn ^ c.vp[0];
        q.push_back(it);
        n++;
      end
    end
    for (int r = 0; r < c.rem; r++) begin
      it.tag = tag;
      it.pv = 0; it.col = 0; it.row = 0;
      it.hs = c.hp[0]; it.vs = c.vp[0];
      q.push_back(it);
      n++;
    end
  endtask

  // Monitor side of the scoreboard
  always begin
    bit en;
    @(posedge clk);
    en = dclkEn;
    @(negedge clk);
    if (monOn && q.size() > 0) begin
      if (en) begin
        lastItem = q.pop_front();
        haveLast = 1;
        popCount++;
        checkItem(lastItem, lastItem.tag);
      end else if (haveLast) begin
        checkItem(lastItem, "R11 hold on disabled clock");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2: got run still active, expected frames complete");
    finishRun();
  end

  initial begin
    bcfg_t f[5];
    string tags[5];
    item_t idle;
    int n, start;

    f[0] = '{cs:15, rs:3, w:16, d:6, csub:0, rsub:0, mh:0, mv:0, hb:5, vb:1, rem:3,
             hss:2, hsw:4, hp:0, hd:0, vss:1, vsw:2, vp:0, vd:0};
    tags[0] = "R2 R3 R4 R5 R7 R8 base frame";
    f[1] = '{cs:4, rs:10, w:20, d:8, csub:1, rsub:1, mh:0, mv:0, hb:70, vb:6, rem:0,
             hss:0, hsw:8, hp:1, hd:0, vss:0, vsw:1, vp:1, vd:0};
    tags[1] = "R4 R5 R10 R12 subsample and inverted syncs";
    f[2] = '{cs:7, rs:2, w:32, d:5, csub:2, rsub:0, mh:1, mv:1, hb:61, vb:4, rem:5,
             hss:65, hsw:10, hp:0, hd:0, vss:7, vsw:3, vp:0, vd:0};
    tags[2] = "R6 R7 R8 R12 mirrored both axes";
    f[3] = '{cs:100, rs:20, w:64, d:16, csub:3, rsub:2, mh:0, mv:1, hb:60, vb:5, rem:2,
             hss:3, hsw:5, hp:1, hd:1, vss:0, vsw:2, vp:0, vd:1};
    tags[3] = "R9 R10 R6 R12 data-valid syncs";
    f[4] = '{cs:0, rs:0, w:16, d:16, csub:0, rsub:3, mh:1, mv:0, hb:100, vb:4, rem:1,
             hss:10, hsw:0, hp:0, hd:0, vss:0, vsw:4, vp:0, vd:0};
    tags[4] = "R11 R2 R6 R7 R12 sparse enable";

    idle.pv = 0; idle.hs = 0; idle.vs = 0; idle.row = 0; idle.col = 0; idle.tag = "";

    applyCfg(f[0]);
    repeat (4) begin
      @(negedge clk);
      checkItem(idle, "R1 in reset");
    end
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checkItem(idle, "R1 before first enable");
    end

    build(f[0], tags[0], n);
    start = 0;
    monOn = 1;
    enGate = 1;
    for (int i = 1; i < 5; i++) begin
      wait (popCount > start);
      @(negedge clk);
      applyCfg(f[i]);          // R12: changed while the previous frame runs
      if (i == 4) enMode = 1;
      start += n;
      build(f[i], tags[i], n);
    end
    wait (popCount == start + n);
    enGate = 0;
    @(negedge clk);
    finishRun();
  end
endmodule